// File: doc/BRIEF.md
# Signed Pending-Acknowledgement Transaction Tracker

This block is the transaction-buffer entry that follows one outstanding upgrade miss in a private cache controller. When the controller allocates it, the entry records the line address and the line's current data and dirty flag. It also records the store that is waiting for write permission, and clears a signed count of messages still owed to it. Responses from the network carry a signed acknowledgement field. An invalidation acknowledgement from a peer carries minus one. A data reply carries the number of acknowledgements the requester must still collect. Each arriving field is subtracted from the count, so replies can land in any order. The count may dip below zero before it settles.

Each update leaves the count somewhere. When the count lands on zero, the entry pushes an all-acks event, tagged with the line address, into a small in-order trigger queue. The controller drains that queue. Once the data reply has arrived, the entry sits in the owned-upgrade state. Draining an event there finishes the miss: the waiting store is written into the line, which is marked dirty. An exclusive-unblock pulse goes out, the entry is freed, a lockout timer starts, and the line reports the modified-awaiting-use state.

Top module: `ack_track_entry`

## Requirements
- R1: After reset the entry is invalid. `state_o` is 0 (free), the count is 0, the trigger queue is empty, and `unblock_o`, `lock_busy_o` and `err_o` are low.
- R2: An allocation sets `valid_o`, clears the count to 0, and latches the address. The saved data and saved dirty flag take the allocation values, and so does the line image. `state_o` becomes 1 (waiting for exclusive, no copy) when `alloc_shared_i`=0, or 2 (waiting for exclusive, shared copy held) when it is 1. While the entry stays valid and no new allocation arrives, the saved data and saved dirty flag do not change.
- R3: Every response on a valid entry subtracts `rsp_acks_i` from the count. Both are 8-bit two's-complement values, the arithmetic wraps modulo 256, and the result may be negative.
- R4: A data response (`rsp_is_data_i`=1) in state 1 writes `rsp_data_i` into the line image and moves the entry to state 3 (owned-upgrade).
- R5: A data response in state 2 moves the entry to state 3 and leaves the line image unchanged. An acknowledgement response (`rsp_is_data_i`=0) never changes the state.
- R6: An echo of the entry's own exclusive request (`fwd_valid_i`) subtracts `fwd_acks_i` from the count only in state 3. In states 1 and 2 it changes neither the count nor the queue.
- R7: When an update leaves the count at exactly zero, one event carrying the entry's address is in the queue from the next cycle. An update that leaves the count nonzero pushes nothing.
- R8: The trigger queue holds two events and presents the oldest first on `trig_addr_o`. A pop (`trig_pop_i` while `trig_valid_o`) removes the oldest event. A push into a full queue is a protocol violation.
- R9: A pop in state 3 finishes the miss. One cycle later the line image holds the pending store data and `line_dirty_o` is 1. `unblock_o` is high for exactly one cycle, `valid_o` is 0, and `state_o` is 4 (modified, lockout).
- R10: After completion, `lock_busy_o` is high for exactly LOCK_CYCLES consecutive cycles.
- R11: A response or echo while the entry is invalid raises `err_o` for one cycle and leaves the count unchanged.
- R12: A pop while the entry is in state 1 or 2 removes the event and changes neither the state nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate the entry for a new miss |
| alloc_shared_i | input | 1 | 1: a shared copy is held (state 2); 0: no copy (state 1) |
| alloc_addr_i | input | AW | Line address of the miss |
| alloc_data_i | input | DW | Current line data, saved for writeback replies |
| alloc_dirty_i | input | 1 | Current dirty flag of the line |
| alloc_st_data_i | input | DW | Store data applied at completion |
| rsp_valid_i | input | 1 | Response present |
| rsp_is_data_i | input | 1 | 1: data reply, 0: acknowledgement |
| rsp_acks_i | input | CW | Signed acknowledgement field of the response |
| rsp_data_i | input | DW | Data carried by a data reply |
| fwd_valid_i | input | 1 | Own exclusive request echoed back |
| fwd_acks_i | input | CW | Signed acknowledgement field of the echo |
| trig_pop_i | input | 1 | Controller consumes the oldest trigger event |
| valid_o | output | 1 | Entry allocated |
| state_o | output | 3 | 0 free, 1 no-copy upgrade, 2 shared upgrade, 3 owned-upgrade, 4 modified lockout |
| addr_o | output | AW | Latched line address |
| pend_cnt_o | output | CW | Signed pending-message count |
| sav_data_o | output | DW | Data saved at allocation |
| sav_dirty_o | output | 1 | Dirty flag saved at allocation |
| line_data_o | output | DW | Line image |
| line_dirty_o | output | 1 | Line dirty flag |
| trig_valid_o | output | 1 | Trigger queue not empty |
| trig_addr_o | output | AW | Address of the oldest trigger event |
| unblock_o | output | 1 | One-cycle exclusive-unblock pulse |
| lock_busy_o | output | 1 | Lockout timer running |
| err_o | output | 1 | One-cycle pulse for an update to an invalid entry |

## Verification
The counting path is swept over every data-reply ack value from 0 to 6. The data reply is placed at every position among the matching minus-one acknowledgements, and both starting states are used. This separates an order-dependent count from a true signed sum, and shows that the event fires only on the final update. A wrap pattern (−128, then +1, then +127) shows that the count is two's complement modulo 256 rather than saturating. Echo, stale-pop, queue-order and invalid-entry patterns each isolate one gating condition: echoes ignored outside the owned-upgrade state, pops that only drain, oldest-first order, and the error pulse.

// File: rtl/ack_track_pkg.sv
package ack_track_pkg;
  typedef enum logic [2:0] {
    TS_FREE = 3'd0,
    TS_IMX  = 3'd1,
    TS_SMX  = 3'd2,
    TS_OMX  = 3'd3,
    TS_MMW  = 3'd4
  } trk_state_e;
endpackage

// File: rtl/trk_fifo.sv
module trk_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic         full_o,
  output logic [W-1:0] head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CNW-1:0] used;
  logic           do_push, do_pop;

  assign valid_o = (used != '0);
  assign full_o  = (used == CNW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so that it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/trk_pend.sv
module trk_pend #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          a_en_i,
  input  logic [CW-1:0] a_i,
  input  logic          b_en_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_nxt_o
);
  logic signed [CW-1:0] cnt_q, nxt;
  logic signed [CW-1:0] a_term, b_term;

  always_comb begin
    a_term = a_en_i ? $signed(a_i) : '0;
    b_term = b_en_i ? $signed(b_i) : '0;
    nxt    = cnt_q - a_term - b_term;
  end

  assign zero_nxt_o = (a_en_i || b_en_i) && (nxt == '0);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)           cnt_q <= '0;
    else if (a_en_i || b_en_i)  cnt_q <= nxt;
  end
endmodule

// File: rtl/trk_lock.sv
module trk_lock #(
  parameter int CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(CYC + 1);
  logic [TW-1:0] left_q;

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst)               left_q <= '0;
    else if (start_i)      left_q <= TW'(CYC);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/ack_track_entry.sv
module ack_track_entry
  import ack_track_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int CW          = 8,
  parameter int QDEPTH      = 2,
  parameter int LOCK_CYCLES = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_i,
  input  logic          alloc_shared_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [DW-1:0] alloc_data_i,
  input  logic          alloc_dirty_i,
  input  logic [DW-1:0] alloc_st_data_i,
  input  logic          rsp_valid_i,
  input  logic          rsp_is_data_i,
  input  logic [CW-1:0] rsp_acks_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          fwd_valid_i,
  input  logic [CW-1:0] fwd_acks_i,
  input  logic          trig_pop_i,
  output logic          valid_o,
  output logic [2:0]    state_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] pend_cnt_o,
  output logic [DW-1:0] sav_data_o,
  output logic          sav_dirty_o,
  output logic [DW-1:0] line_data_o,
  output logic          line_dirty_o,
  output logic          trig_valid_o,
  output logic [AW-1:0] trig_addr_o,
  output logic          unblock_o,
  output logic          lock_busy_o,
  output logic          err_o
);
  trk_state_e    state_q;
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sav_data_q, line_data_q, st_data_q;
  logic          sav_dirty_q, line_dirty_q;
  logic          unblock_q, err_q;

  logic upd_rsp, upd_fwd, zero_nxt;
  logic q_push, q_pop, q_full, q_valid;
  logic in_upgrade, complete;

  assign in_upgrade = (state_q == TS_IMX) || (state_q == TS_SMX) || (state_q == TS_OMX);
  assign upd_rsp    = rsp_valid_i && valid_q && !alloc_i;
  assign upd_fwd    = fwd_valid_i && valid_q && !alloc_i && (state_q == TS_OMX);
  assign q_push     = zero_nxt && in_upgrade && valid_q;
  assign q_pop      = trig_pop_i && q_valid;
  assign complete   = q_pop && valid_q && !alloc_i && (state_q == TS_OMX);

  trk_pend #(.CW(CW)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (alloc_i),
    .a_en_i     (upd_rsp),
    .a_i        (rsp_acks_i),
    .b_en_i     (upd_fwd),
    .b_i        (fwd_acks_i),
    .cnt_o      (pend_cnt_o),
    .zero_nxt_o (zero_nxt)
  );

  trk_fifo #(.W(AW), .DEPTH(QDEPTH)) u_trig (
    .clk         (clk),
    .rst         (rst),
    .push_i      (q_push),
    .push_data_i (addr_q),
    .pop_i       (q_pop),
    .valid_o     (q_valid),
    .full_o      (q_full),
    .head_o      (trig_addr_o)
  );

  trk_lock #(.CYC(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .start_i (complete),
    .busy_o  (lock_busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= TS_FREE;
      valid_q      <= 1'b0;
      addr_q       <= '0;
      sav_data_q   <= '0;
      sav_dirty_q  <= 1'b0;
      line_data_q  <= '0;
      line_dirty_q <= 1'b0;
      st_data_q    <= '0;
      unblock_q    <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      unblock_q <= complete;
      err_q     <= (rsp_valid_i || fwd_valid_i) && !valid_q && !alloc_i;
      if (alloc_i) begin
        valid_q      <= 1'b1;
        state_q      <= alloc_shared_i ? TS_SMX : TS_IMX;
        addr_q       <= alloc_addr_i;
        sav_data_q   <= alloc_data_i;
        sav_dirty_q  <= alloc_dirty_i;
        line_data_q  <= alloc_data_i;
        line_dirty_q <= alloc_dirty_i;
        st_data_q    <= alloc_st_data_i;
      end else if (complete) begin
        valid_q      <= 1'b0;
        state_q      <= TS_MMW;
        line_data_q  <= st_data_q;
        line_dirty_q <= 1'b1;
      end else if (upd_rsp && rsp_is_data_i) begin
        if (state_q == TS_IMX) begin
          line_data_q <= rsp_data_i;
          state_q     <= TS_OMX;
        end else if (state_q == TS_SMX) begin
          state_q     <= TS_OMX;
        end
      end
    end
  end

  assign valid_o      = valid_q;
  assign state_o      = state_q;
  assign addr_o       = addr_q;
  assign sav_data_o   = sav_data_q;
  assign sav_dirty_o  = sav_dirty_q;
  assign line_data_o  = line_data_q;
  assign line_dirty_o = line_dirty_q;
  assign trig_valid_o = q_valid;
  assign unblock_o    = unblock_q;
  assign err_o        = err_q;
endmodule

// File: rtl/ack_track_chk.sv
module ack_track_chk #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_i,
  input logic          rsp_valid_i,
  input logic          rsp_is_data_i,
  input logic          fwd_valid_i,
  input logic          valid_o,
  input logic [2:0]    state_o,
  input logic [CW-1:0] pend_cnt_o,
  input logic [DW-1:0] sav_data_o,
  input logic          sav_dirty_o,
  input logic          unblock_o,
  input logic          lock_busy_o,
  input logic          err_o,
  input logic          q_push,
  input logic          q_full
);
  AST_NO_TRIG_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_push |-> !q_full); // R8

  AST_ALLOC_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    alloc_i |=> (pend_cnt_o == '0) && valid_o); // R2

  AST_SAVED_HELD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !alloc_i) |=> $stable(sav_data_o) && $stable(sav_dirty_o)); // R2

  AST_IM_DATA_OWNED: assert property (@(posedge clk) disable iff (rst)
    (valid_o && state_o == 3'd1 && rsp_valid_i && rsp_is_data_i && !alloc_i)
      |=> (state_o == 3'd3 || !valid_o)); // R4

  AST_UNBLOCK_FREES: assert property (@(posedge clk) disable iff (rst)
    unblock_o |-> (!valid_o && state_o == 3'd4 && lock_busy_o)); // R9

  AST_UNBLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
    unblock_o |=> !unblock_o); // R9

  AST_IDLE_UPDATE_ERR: assert property (@(posedge clk) disable iff (rst)
    ((rsp_valid_i || fwd_valid_i) && !valid_o && !alloc_i)
      |=> (err_o && $stable(pend_cnt_o))); // R11
endmodule

bind ack_track_entry ack_track_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .alloc_i       (alloc_i),
  .rsp_valid_i   (rsp_valid_i),
  .rsp_is_data_i (rsp_is_data_i),
  .fwd_valid_i   (fwd_valid_i),
  .valid_o       (valid_o),
  .state_o       (state_o),
  .pend_cnt_o    (pend_cnt_o),
  .sav_data_o    (sav_data_o),
  .sav_dirty_o   (sav_dirty_o),
  .unblock_o     (unblock_o),
  .lock_busy_o   (lock_busy_o),
  .err_o         (err_o),
  .q_push        (q_push),
  .q_full        (q_full)
);

// File: tb/sim_ack_track_entry.sv
`timescale 1ns/1ps
module sim_ack_track_entry;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int LK = 5;

  logic clk = 1'b0;
  logic rst;
  logic alloc_i, alloc_shared_i, alloc_dirty_i;
  logic [AW-1:0] alloc_addr_i;
  logic [DW-1:0] alloc_data_i, alloc_st_data_i, rsp_data_i;
  logic rsp_valid_i, rsp_is_data_i, fwd_valid_i, trig_pop_i;
  logic [CW-1:0] rsp_acks_i, fwd_acks_i;
  logic valid_o, sav_dirty_o, line_dirty_o, trig_valid_o, unblock_o, lock_busy_o, err_o;
  logic [2:0] state_o;
  logic [AW-1:0] addr_o, trig_addr_o;
  logic [CW-1:0] pend_cnt_o;
  logic [DW-1:0] sav_data_o, line_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ack_track_entry #(.AW(AW), .DW(DW), .CW(CW), .QDEPTH(2), .LOCK_CYCLES(LK)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    alloc_i = 0; alloc_shared_i = 0; alloc_dirty_i = 0; alloc_addr_i = '0;
    alloc_data_i = '0; alloc_st_data_i = '0; rsp_valid_i = 0; rsp_is_data_i = 0;
    rsp_acks_i = '0; rsp_data_i = '0; fwd_valid_i = 0; fwd_acks_i = '0; trig_pop_i = 0;
  endtask

  // inputs were set just after a falling edge; let one rising edge take them
  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic do_alloc(input logic sh, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic dty, input logic [DW-1:0] st);
    alloc_i = 1; alloc_shared_i = sh; alloc_addr_i = a; alloc_data_i = d;
    alloc_dirty_i = dty; alloc_st_data_i = st;
    tick();
  endtask

  task automatic do_rsp(input logic dat, input byte acks, input logic [DW-1:0] d);
    rsp_valid_i = 1; rsp_is_data_i = dat; rsp_acks_i = acks; rsp_data_i = d;
    tick();
  endtask

  task automatic do_fwd(input byte acks);
    fwd_valid_i = 1; fwd_acks_i = acks;
    tick();
  endtask

  task automatic do_pop();
    trig_pop_i = 1;
    tick();
  endtask

  task automatic finish_and_lock(input logic [DW-1:0] st);
    int busy_n;
    do_pop();
    check("R9 unblock", int'(unblock_o), 1);
    check("R9 valid", int'(valid_o), 0);
    check("R9 state", int'(state_o), 4);
    check("R9 line data", int'(line_data_o), int'(st));
    check("R9 dirty", int'(line_dirty_o), 1);
    busy_n = 0;
    while (lock_busy_o && busy_n < 100) begin
      busy_n++;
      tick();
      if (busy_n == 1) check("R9 unblock one cycle", int'(unblock_o), 0);
    end
    check("R10 lock cycles", busy_n, LK);
  endtask

  initial begin
    quiet();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 valid", int'(valid_o), 0);
    check("R1 state", int'(state_o), 0);
    check("R1 count", int'(pend_cnt_o), 0);
    check("R1 queue", int'(trig_valid_o), 0);
    check("R1 pulses", int'({unblock_o, lock_busy_o, err_o}), 0);
    rst = 0;

    // signed-count sweep: data reply with ack value n at every position among n minus-one acks
    for (int sh = 0; sh < 2; sh++) begin
      for (int n = 0; n <= 6; n++) begin
        for (int k = 0; k <= n; k++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] orig, dv, st;
          logic [DW-1:0] exp_line;
          byte ec;
          a = AW'(16 * n + k + 1);
          orig = DW'(16'h1100 + 16 * n + k);
          dv   = DW'(16'hA000 + 16 * n + k);
          st   = DW'(16'h5500 + 16 * n + k);
          do_alloc(sh[0], a, orig, k[0], st);
          check("R2 valid", int'(valid_o), 1);
          check("R2 count", int'(pend_cnt_o), 0);
          check("R2 state", int'(state_o), sh == 1 ? 2 : 1);
          check("R2 addr", int'(addr_o), int'(a));
          check("R2 saved", int'({sav_dirty_o, sav_data_o}), int'({k[0], orig}));
          ec = 0;
          exp_line = orig;
          for (int i = 0; i <= n; i++) begin
            if (i == k) begin
              do_rsp(1'b1, byte'(n), dv);
              ec = ec - byte'(n);
              if (sh == 0) exp_line = dv;
              check(sh == 0 ? "R4 state" : "R5 state", int'(state_o), 3);
              check(sh == 0 ? "R4 line" : "R5 line", int'(line_data_o), int'(exp_line));
            end else begin
              do_rsp(1'b0, -8'sd1, '0);
              ec = ec + 1'sb1 * 0 + 8'sd0 - (-8'sd1);
              check("R5 ack keeps state", int'(state_o), (i < k) ? (sh == 1 ? 2 : 1) : 3);
            end
            check("R3 count", int'($signed(pend_cnt_o)), int'(ec));
            check("R7 push on zero only", int'(trig_valid_o), (i == n) ? 1 : 0);
          end
          check("R7 event addr", int'(trig_addr_o), int'(a));
          finish_and_lock(st);
          check("R7 queue drained", int'(trig_valid_o), 0);
        end
      end
    end

    // wrap: -128 then +1 then +127
    do_alloc(1'b0, 8'h77, 16'h0101, 1'b0, 16'h0202);
    do_rsp(1'b0, -8'sd128, '0);
    check("R3 wrap low", int'($signed(pend_cnt_o)), -128);
    do_rsp(1'b0, 8'sd1, '0);
    check("R3 wrap to 127", int'($signed(pend_cnt_o)), 127);
    check("R7 no push nonzero", int'(trig_valid_o), 0);
    do_rsp(1'b0, 8'sd127, '0);
    check("R3 back to zero", int'($signed(pend_cnt_o)), 0);
    check("R7 push", int'(trig_valid_o), 1);
    do_pop();
    check("R12 stale pop state", int'(state_o), 1);
    check("R12 stale pop valid", int'(valid_o), 1);
    check("R12 stale pop drained", int'(trig_valid_o), 0);

    // queue order with two events, both popped outside the owned state
    do_alloc(1'b0, 8'hA1, 16'h0, 1'b0, 16'h0);
    do_rsp(1'b0, 8'sd0, '0);
    do_alloc(1'b0, 8'hB2, 16'h0, 1'b0, 16'h0);
    do_rsp(1'b0, 8'sd0, '0);
    check("R8 oldest first", int'(trig_addr_o), 'hA1);
    do_pop();
    check("R12 state unchanged", int'(state_o), 1);
    check("R12 count unchanged", int'(pend_cnt_o), 0);
    check("R8 second event", int'(trig_addr_o), 'hB2);
    check("R8 still valid", int'(trig_valid_o), 1);
    do_pop();
    check("R8 empty", int'(trig_valid_o), 0);

    // own-request echo: ignored before data, counted once owned
    do_alloc(1'b1, 8'h3C, 16'hC0DE, 1'b1, 16'hBEEF);
    do_fwd(8'sd3);
    check("R6 echo ignored count", int'(pend_cnt_o), 0);
    check("R6 echo ignored queue", int'(trig_valid_o), 0);
    check("R6 echo ignored state", int'(state_o), 2);
    do_rsp(1'b1, 8'sd2, 16'hDEAD);
    check("R5 shared data keeps line", int'(line_data_o), 'hC0DE);
    check("R3 count after data", int'($signed(pend_cnt_o)), -2);
    do_fwd(-8'sd2);
    check("R6 echo counted", int'(pend_cnt_o), 0);
    check("R6 echo push", int'(trig_valid_o), 1);
    finish_and_lock(16'hBEEF);

    // updates to a freed entry
    do_rsp(1'b0, 8'sd5, '0);
    check("R11 err on response", int'(err_o), 1);
    check("R11 count kept", int'(pend_cnt_o), 0);
    tick();
    check("R11 err one cycle", int'(err_o), 0);
    do_fwd(8'sd4);
    check("R11 err on echo", int'(err_o), 1);
    check("R11 count kept echo", int'(pend_cnt_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule